// File: doc/BRIEF.md
# Signed Booth-Recoded Carry-Save Tree Multiplier

This block multiplies two N-bit two's-complement numbers and returns their 2N-bit signed product. Each bit of the multiplier operand becomes a signed digit (+1, 0 or -1) by looking at that bit and the bit below it. A digit picks one partial product: the multiplicand, zero, or the two's complement of the multiplicand. The chosen row is sign-extended to 2N bits and shifted left by the digit's position.

The N partial-product rows pass through a Wallace-style tree of full-adder 3:2 compressors. The tree works level by level until two rows remain. A parallel-prefix carry look-ahead adder then sums those two rows. Only the low 2N bits of that sum are kept.

The datapath is fully combinational. When the `REG_OUT` parameter is 1 (the default), the product is captured in an output register. That register loads only while the `load` input is high and is cleared by an asynchronous active-low reset. When `REG_OUT` is 0, the product follows the operands with no clock involved.

Top module: `booth_wallace_mul`

## Requirements
- R1: Digit i is formed from mr[i] and mr[i-1], with mr[-1] taken as 0. The pair (1,0) gives -1, the pair (0,1) gives +1, and the pairs (0,0) and (1,1) give 0. The weighted sum of the digits equals the signed value of mr; for example, 4-bit 1011 gives -1,+1,0,-1 from the top digit down. Multiplier patterns in which every digit is nonzero, or only the top digit is nonzero, still give the correct product.
- R2: For every operand pair, the product equals the signed product of md and mr in 2N bits. This is checked for all pairs at N=4 and for 10,000 random pairs at N=8.
- R3: The most negative multiplicand, -2^(N-1), is negated correctly. For N=8, -128 × -128 gives 16'h4000 and -128 × -1 gives 16'h0080.
- R4: A negative product has all of its upper bits set through bit 2N-1. For N=8, 1 × -1 gives 16'hFFFF and 127 × -128 gives 16'hC080.
- R5: For N=4, 0110 × 1011 gives 8'b1110_0010, which is -30.
- R6: With REG_OUT=1, a rising clock edge with load high captures the product of the md and mr present at that edge. Before that edge, prod still shows its old value.
- R7: With REG_OUT=1 and load low, prod keeps its value on every clock edge, whatever happens to md and mr.
- R8: Driving rst_n low clears prod to zero at once, with no clock edge needed. prod stays zero while rst_n is held low.
- R9: If either operand is zero, the product is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| md | input | N | Multiplicand, two's complement |
| mr | input | N | Multiplier, two's complement, Booth-recoded |
| load | input | 1 | Output register load enable |
| prod | output | 2N | Signed product, registered when REG_OUT=1 |

## Verification
A wrong recoded digit has a fixed effect: the product moves by a signed multiple of md·2^i. A wrong compressor cell or prefix carry also has a fixed effect: some power of two is added to or dropped from the sum. In both cases the error shows on prod in the same cycle in the combinational variant, and one edge after load in the registered variant. Such a fault only shows for operand pairs that reach the broken digit or column, which is why every 4-bit pair is run and wide random pairs are added at N=8. The inner checker compares the two tree rows and the digit vector with the reference on every evaluation, so it points to the stage at fault before the result reaches the register.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // Control pair produced for one Booth digit
    typedef struct packed {
        logic nz;   // digit is +1 or -1
        logic neg;  // digit is -1
    } booth_ctl_t;

    // Rows left after one level of 3:2 compression
    function automatic int rows_after(input int rows);
        return (rows / 3) * 2 + (rows % 3);
    endfunction

    // Row count entering a given level of the tree
    function automatic int rows_at_level(input int n, input int lvl);
        int r;
        r = n;
        for (int k = 0; k < lvl; k++) r = rows_after(r);
        return r;
    endfunction

    // Number of compression levels needed to reach two rows
    function automatic int tree_levels(input int n);
        int r;
        int l;
        r = n;
        l = 0;
        while (r > 2) begin
            r = rows_after(r);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import bwm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]             mr,
    output booth_ctl_t [N-1:0]       ctl
);
    for (genvar i = 0; i < N; i++) begin : g_digit
        logic below;
        if (i == 0) begin : g_lsb
            assign below = 1'b0;
        end else begin : g_upper
            assign below = mr[i-1];
        end
        assign ctl[i].nz  = mr[i] ^ below;
        assign ctl[i].neg = mr[i] & ~below;
    end
endmodule

// File: rtl/pp_gen.sv
module pp_gen
    import bwm_pkg::*;
#(
    parameter int N = 8,
    localparam int W = 2 * N
) (
    input  logic [N-1:0]            md,
    input  booth_ctl_t [N-1:0]      ctl,
    output logic [N-1:0][W-1:0]     rows
);
    logic [W-1:0] md_pos;
    logic [W-1:0] md_neg;

    assign md_pos = {{N{md[N-1]}}, md};
    assign md_neg = ~md_pos + W'(1);

    for (genvar i = 0; i < N; i++) begin : g_row
        logic [W-1:0] pick;
        always_comb begin
            unique case ({ctl[i].nz, ctl[i].neg})
                2'b10:   pick = md_pos;
                2'b11:   pick = md_neg;
                default: pick = '0;
            endcase
        end
        assign rows[i] = pick << i;
    end
endmodule

// File: rtl/csa3.sv
module csa3 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    logic [W-1:0] co;

    for (genvar j = 0; j < W; j++) begin : g_fa
        assign sum[j] = a[j] ^ b[j] ^ c[j];
        assign co[j]  = (a[j] & b[j]) | (a[j] & c[j]) | (b[j] & c[j]);
    end

    assign carry = {co[W-2:0], 1'b0};
endmodule

// File: rtl/csa_tree.sv
module csa_tree
    import bwm_pkg::*;
#(
    parameter int N = 8,
    localparam int W = 2 * N,
    localparam int LEVELS = tree_levels(N)
) (
    input  logic [N-1:0][W-1:0] rows_in,
    output logic [W-1:0]        row_a,
    output logic [W-1:0]        row_b
);
    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int R = rows_at_level(N, l);
        logic [W-1:0] row [R];

        if (l == 0) begin : g_entry
            for (genvar k = 0; k < R; k++) begin : g_in
                assign row[k] = rows_in[k];
            end
        end else begin : g_reduce
            localparam int RP = rows_at_level(N, l - 1);
            localparam int G  = RP / 3;
            for (genvar g = 0; g < G; g++) begin : g_grp
                csa3 #(.W(W)) u_csa (
                    .a     (g_lvl[l-1].row[3*g]),
                    .b     (g_lvl[l-1].row[3*g+1]),
                    .c     (g_lvl[l-1].row[3*g+2]),
                    .sum   (row[2*g]),
                    .carry (row[2*g+1])
                );
            end
            for (genvar k = 0; k < RP % 3; k++) begin : g_pass
                assign row[2*G+k] = g_lvl[l-1].row[3*G+k];
            end
        end
    end

    assign row_a = g_lvl[LEVELS].row[0];
    assign row_b = g_lvl[LEVELS].row[1];
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int W = 16,
    localparam int L = $clog2(W)
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [L:0][W-1:0] gen;
    logic [L:0][W-1:0] prp;

    assign gen[0] = a & b;
    assign prp[0] = a ^ b;

    for (genvar k = 1; k <= L; k++) begin : g_stage
        localparam int D = 1 << (k - 1);
        for (genvar j = 0; j < W; j++) begin : g_bit
            if (j >= D) begin : g_merge
                assign gen[k][j] = gen[k-1][j] | (prp[k-1][j] & gen[k-1][j-D]);
                assign prp[k][j] = prp[k-1][j] & prp[k-1][j-D];
            end else begin : g_copy
                assign gen[k][j] = gen[k-1][j];
                assign prp[k][j] = prp[k-1][j];
            end
        end
    end

    assign sum = prp[0] ^ {gen[L][W-2:0], 1'b0};
endmodule

// File: rtl/booth_wallace_mul.sv
module booth_wallace_mul
    import bwm_pkg::*;
#(
    parameter int N = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int W = 2 * N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] md,
    input  logic [N-1:0] mr,
    input  logic         load,
    output logic [W-1:0] prod
);
    booth_ctl_t [N-1:0]    ctl;
    logic [N-1:0][W-1:0]   pp_rows;
    logic [W-1:0]          row_a;
    logic [W-1:0]          row_b;
    logic [W-1:0]          prod_c;
    logic [N-1:0]          digit_nz;
    logic [N-1:0]          digit_neg;

    booth_recoder #(.N(N)) u_rec (
        .mr  (mr),
        .ctl (ctl)
    );

    for (genvar i = 0; i < N; i++) begin : g_ctl
        assign digit_nz[i]  = ctl[i].nz;
        assign digit_neg[i] = ctl[i].neg;
    end

    pp_gen #(.N(N)) u_pp (
        .md   (md),
        .ctl  (ctl),
        .rows (pp_rows)
    );

    csa_tree #(.N(N)) u_tree (
        .rows_in (pp_rows),
        .row_a   (row_a),
        .row_b   (row_b)
    );

    cla_adder #(.W(W)) u_cla (
        .a   (row_a),
        .b   (row_b),
        .sum (prod_c)
    );

    if (REG_OUT) begin : g_reg
        logic [W-1:0] prod_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod_q <= '0;
            end else if (load) begin
                prod_q <= prod_c;
            end
        end
        assign prod = prod_q;
    end else begin : g_comb
        assign prod = prod_c;
    end
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
    parameter int N = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int W = 2 * N
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] md,
    input logic [N-1:0] mr,
    input logic         load,
    input logic [W-1:0] prod,
    input logic [W-1:0] row_a,
    input logic [W-1:0] row_b,
    input logic [N-1:0] nz,
    input logic [N-1:0] neg
);
    logic [W-1:0] ref_prod;
    logic [W-1:0] digit_val;

    assign ref_prod = $signed({{N{md[N-1]}}, md}) * $signed({{N{mr[N-1]}}, mr});

    always_comb begin
        digit_val = '0;
        for (int i = 0; i < N; i++) begin
            if (nz[i]) begin
                if (neg[i]) digit_val = digit_val - (W'(1) << i);
                else        digit_val = digit_val + (W'(1) << i);
            end
        end
    end

    always_comb begin
        if (!$isunknown({md, mr})) begin
            AST_DIGITS_WEIGH_MR: assert (digit_val == {{N{mr[N-1]}}, mr}); // R1
            AST_TREE_ROWS_SUM: assert (W'(row_a + row_b) == ref_prod); // R2
            if (!REG_OUT) begin
                AST_COMB_PRODUCT: assert (prod == ref_prod); // R2
            end
        end
    end

    if (REG_OUT) begin : g_seq
        AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> prod == $past(ref_prod)); // R6
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(prod)); // R7
        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |-> prod == '0); // R8
        AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            (load && (md == '0 || mr == '0)) |=> prod == '0); // R9
        AST_PRODUCT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (load && md != '0 && mr != '0 && !(md == {1'b1, {(N-1){1'b0}}} && mr == {1'b1, {(N-1){1'b0}}}))
            |=> prod[W-1] == $past(md[N-1] ^ mr[N-1])); // R4
    end
endmodule

bind booth_wallace_mul bwm_checker #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .md    (md),
    .mr    (mr),
    .load  (load),
    .prod  (prod),
    .row_a (row_a),
    .row_b (row_b),
    .nz    (digit_nz),
    .neg   (digit_neg)
);

// File: tb/booth_wallace_mul_test.sv
module booth_wallace_mul_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  md = '0;
    logic [7:0]  mr = '0;
    logic        load = 1'b0;
    logic [15:0] prod;
    logic [3:0]  md4 = '0;
    logic [3:0]  mr4 = '0;
    logic [7:0]  prod4;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_wallace_mul #(.N(8), .REG_OUT(1'b1)) uut (
        .clk (clk), .rst_n (rst_n), .md (md), .mr (mr), .load (load), .prod (prod)
    );

    booth_wallace_mul #(.N(4), .REG_OUT(1'b0)) uut_small (
        .clk (clk), .rst_n (rst_n), .md (md4), .mr (mr4), .load (1'b0), .prod (prod4)
    );

    function automatic logic [15:0] ref16(input logic [7:0] a, input logic [7:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[15:0];
    endfunction

    function automatic logic [7:0] ref8(input logic [3:0] a, input logic [3:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[7:0];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one multiply through the registered unit, result read one edge later
    task automatic run_mul(input string req, input logic [7:0] a, input logic [7:0] b,
                           input logic [15:0] exp);
        @(negedge clk);
        md = a;
        mr = b;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(req, prod, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8 reset value", prod, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_example();
        md4 = 4'b0110;
        mr4 = 4'b1011;
        #1;
        check("R5 4-bit example", {8'h00, prod4}, 16'h00E2);
        run_mul("R5 8-bit example", 8'd6, 8'hFB, 16'hFFE2);
    endtask

    task automatic t_recode();
        run_mul("R1 all digits nonzero", 8'd3, 8'h55, ref16(8'd3, 8'h55));
        run_mul("R1 top digit only", 8'd5, 8'h80, 16'hFD80);
        run_mul("R1 long run of ones", 8'hF9, 8'h7F, ref16(8'hF9, 8'h7F));
        run_mul("R1 alternating", 8'h6D, 8'hAA, ref16(8'h6D, 8'hAA));
    endtask

    task automatic t_exhaustive4();
        int bad = 0;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                md4 = 4'(a);
                mr4 = 4'(b);
                #1;
                if (prod4 !== ref8(4'(a), 4'(b))) begin
                    bad++;
                    check("R2 exhaustive N=4", {8'h00, prod4}, {8'h00, ref8(4'(a), 4'(b))});
                end
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL R2 exhaustive N=4: actual %0d wrong pairs expected 0", bad);
        end
    endtask

    task automatic t_edges();
        run_mul("R3 min times min", 8'h80, 8'h80, 16'h4000);
        run_mul("R3 min times -1", 8'h80, 8'hFF, 16'h0080);
        run_mul("R4 one times -1", 8'h01, 8'hFF, 16'hFFFF);
        run_mul("R4 max times min", 8'h7F, 8'h80, 16'hC080);
        run_mul("R9 zero multiplicand", 8'h00, 8'h9C, 16'h0000);
        run_mul("R9 zero multiplier", 8'hB3, 8'h00, 16'h0000);
    endtask

    task automatic t_load_timing();
        run_mul("R6 seed", 8'd5, 8'd7, 16'd35);
        @(negedge clk);
        md = 8'd9;
        mr = 8'hFD;
        load = 1'b1;
        #1;
        check("R6 old value before edge", prod, 16'd35);
        @(negedge clk);
        load = 1'b0;
        check("R6 captured at edge", prod, 16'hFFE5);
    endtask

    task automatic t_hold();
        run_mul("R7 seed", 8'd12, 8'd11, 16'd132);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            md = 8'(k * 37 + 3);
            mr = 8'(k * 91 + 17);
        end
        @(negedge clk);
        check("R7 hold while idle", prod, 16'd132);
    endtask

    task automatic t_async_reset();
        run_mul("R8 seed", 8'h44, 8'h21, ref16(8'h44, 8'h21));
        #2;
        rst_n = 1'b0;
        #1;
        check("R8 asynchronous clear", prod, 16'h0000);
        @(negedge clk);
        md = 8'h7F;
        mr = 8'h7F;
        load = 1'b1;
        @(negedge clk);
        check("R8 held in reset", prod, 16'h0000);
        load = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_random();
        int bad = 0;
        for (int k = 0; k < 10000; k++) begin
            logic [7:0] a;
            logic [7:0] b;
            a = 8'($urandom);
            b = 8'($urandom);
            @(negedge clk);
            md = a;
            mr = b;
            load = 1'b1;
            @(negedge clk);
            load = 1'b0;
            if (prod !== ref16(a, b)) begin
                bad++;
                if (bad < 5) check("R2 random N=8", prod, ref16(a, b));
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL R2 random N=8: actual %0d wrong pairs expected 0", bad);
        end
    endtask

    initial begin
        t_reset();
        t_example();
        t_recode();
        t_exhaustive4();
        t_edges();
        t_load_timing();
        t_hold();
        t_async_reset();
        t_random();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule